// File: doc/BRIEF.md
# Bank Conflict Splitter

This block sits between a requester that issues a group of parallel memory requests and a set of independent memory banks. The group always holds as many requests as there are banks. Each request arrives with its target already resolved: a bank number and an address inside that bank. When every request in the group aims at a different bank, the whole group goes out in one cycle. When two or more requests share a bank, the block sends the group as a series of waves. In each wave, every bank receives at most one request.

The output has one slot per bank. Each slot carries a valid bit, the in-bank address, and the position of the request inside the original group, so that returned data can be put back in order later. Markers flag the first and the last wave of a group. A further flag, raised with the first wave, says that the group went out in a single cycle with no conflict. While a group is being issued, the block holds its input ready low and takes no new group.

Top module: `conflict_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and every bit of `out_valid` is 0.
- R2: A group is taken on a clock edge where `req_valid` and `req_ready` are both 1. Its first wave appears in the cycle after that edge. `req_ready` stays 0 through every wave of the group and returns to 1 in the cycle after the last wave.
- R3: A valid output slot b (bits `b*BANK_W +: BANK_W` of `out_idx`, `b*ADDR_W +: ADDR_W` of `out_addr`) carries a request whose bank field equals b.
- R4: In each wave, each bank slot is given to the lowest-numbered request that targets that bank and has not yet been sent.
- R5: The number of waves in a group equals the largest number of its requests that target a single bank.
- R6: Every request of a group is issued exactly once, carrying its own in-bank address and its group position (request i uses bits `i*BANK_W +: BANK_W` of `req_bank` and `i*ADDR_W +: ADDR_W` of `req_addr`).
- R7: `out_conflict_free` is 1 only on the first wave of a group that needs exactly one wave, and is 0 in every other cycle.
- R8: `out_first` is 1 only on the first wave of a group and `out_last` only on its final wave. Both are 0 while idle.
- R9: While a group is being issued, `req_valid`, `req_bank` and `req_addr` have no effect on the waves of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request group is offered |
| req_ready | output | 1 | Block can take a new group |
| req_bank | input | NBANK*BANK_W | Bank number of each request, request i in field i |
| req_addr | input | NBANK*ADDR_W | In-bank address of each request, request i in field i |
| out_valid | output | NBANK | Slot b holds a request for bank b |
| out_addr | output | NBANK*ADDR_W | In-bank address per slot |
| out_idx | output | NBANK*BANK_W | Group position of the request in each slot |
| out_first | output | 1 | First wave of a group |
| out_last | output | 1 | Final wave of a group |
| out_conflict_free | output | 1 | Group completes in one wave |

## Verification
The bench builds the block with four banks and 8-bit addresses. With four banks, a handful of directed groups reaches every wave count from one to four: a permutation, two pairs, a three-deep pile on one bank, and all requests on a single bank. Each wave is predicted from a small greedy model written in the bench, and the observed wave count is compared with the largest per-bank demand. One group is issued while conflicting traffic is offered on the input, to show that the input has no effect until the group finishes. Groups are also sent back to back.

// File: rtl/csplit_pkg.sv
package csplit_pkg;
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_ISSUE = 1'b1
  } phase_t;
endpackage

// File: rtl/csplit_pick.sv
module csplit_pick #(
  parameter int NBANK   = 4,
  parameter int BANK_W  = 2,
  parameter int MY_BANK = 0
) (
  input  logic [NBANK*BANK_W-1:0] banks,
  input  logic [NBANK-1:0]        pend,
  output logic                    hit,
  output logic [NBANK-1:0]        win,
  output logic [BANK_W-1:0]       win_idx
);
  function automatic logic [NBANK-1:0] aimed_here(input logic [NBANK*BANK_W-1:0] bv);
    logic [NBANK-1:0] m;
    for (int i = 0; i < NBANK; i++)
      m[i] = (bv[i*BANK_W +: BANK_W] == BANK_W'(MY_BANK));
    return m;
  endfunction

  logic [NBANK-1:0] want;
  assign want = pend & aimed_here(banks);

  always_comb begin
    win     = '0;
    win_idx = '0;
    hit     = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      if (want[i] && !hit) begin
        win[i]  = 1'b1;
        win_idx = BANK_W'(i);
        hit     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/csplit_slot.sv
module csplit_slot #(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 8
) (
  input  logic                    issuing,
  input  logic                    hit,
  input  logic [BANK_W-1:0]       idx,
  input  logic [NBANK*ADDR_W-1:0] addrs,
  output logic                    valid,
  output logic [ADDR_W-1:0]       addr
);
  assign valid = issuing & hit;
  assign addr  = valid ? addrs[idx*ADDR_W +: ADDR_W] : '0;
endmodule

// File: rtl/conflict_splitter.sv
module conflict_splitter #(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 8,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [NBANK*BANK_W-1:0] req_bank,
  input  logic [NBANK*ADDR_W-1:0] req_addr,
  output logic [NBANK-1:0]        out_valid,
  output logic [NBANK*ADDR_W-1:0] out_addr,
  output logic [NBANK*BANK_W-1:0] out_idx,
  output logic                    out_first,
  output logic                    out_last,
  output logic                    out_conflict_free
);
  import csplit_pkg::*;

  phase_t                  phase_q;
  logic [NBANK-1:0]        pend_q;
  logic [NBANK*BANK_W-1:0] bank_q;
  logic [NBANK*ADDR_W-1:0] addr_q;
  logic                    first_q;

  logic                    issuing;
  logic                    take_group;
  logic                    wave_last;
  logic [NBANK-1:0]        slot_hit;
  logic [NBANK-1:0]        win_vec [NBANK];
  logic [NBANK-1:0]        grant;

  assign issuing    = (phase_q == PH_ISSUE);
  assign req_ready  = !issuing;
  assign take_group = req_valid && req_ready;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BANK_W-1:0] widx;
    csplit_pick #(.NBANK(NBANK), .BANK_W(BANK_W), .MY_BANK(b)) u_pick (
      .banks  (bank_q),
      .pend   (pend_q),
      .hit    (slot_hit[b]),
      .win    (win_vec[b]),
      .win_idx(widx)
    );
    csplit_slot #(.NBANK(NBANK), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_slot (
      .issuing(issuing),
      .hit    (slot_hit[b]),
      .idx    (widx),
      .addrs  (addr_q),
      .valid  (out_valid[b]),
      .addr   (out_addr[b*ADDR_W +: ADDR_W])
    );
    assign out_idx[b*BANK_W +: BANK_W] = out_valid[b] ? widx : '0;
  end

  always_comb begin
    grant = '0;
    for (int b = 0; b < NBANK; b++) grant = grant | win_vec[b];
  end

  assign wave_last         = issuing && (grant == pend_q);
  assign out_first         = issuing && first_q;
  assign out_last          = wave_last;
  assign out_conflict_free = out_first && wave_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pend_q  <= '0;
      bank_q  <= '0;
      addr_q  <= '0;
      first_q <= 1'b0;
    end else if (take_group) begin
      phase_q <= PH_ISSUE;
      pend_q  <= '1;
      bank_q  <= req_bank;
      addr_q  <= req_addr;
      first_q <= 1'b1;
    end else if (issuing) begin
      pend_q  <= pend_q & ~grant;
      first_q <= 1'b0;
      if (wave_last) phase_q <= PH_IDLE;
    end
  end
endmodule

// File: rtl/conflict_splitter_checker.sv
module conflict_splitter_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [NBANK-1:0] out_valid,
  input logic             out_first,
  input logic             out_last,
  input logic             out_conflict_free
);
  localparam int CW = $clog2(NBANK + 2);
  logic [CW-1:0] wave_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wave_cnt <= '0;
    else if (out_last)  wave_cnt <= '0;
    else if (|out_valid) wave_cnt <= wave_cnt + 1'b1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (out_valid == '0) && !out_first && !out_last);

  a_r2_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (|out_valid));

  a_r2_first_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_first);

  a_r8_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> req_ready);

  a_r7_cf_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_conflict_free |-> (out_first && out_last));

  a_r5_wave_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |-> (wave_cnt < CW'(NBANK)));
endmodule

bind conflict_splitter conflict_splitter_checker #(.NBANK(NBANK)) u_chk (.*);

// File: tb/conflict_splitter_test.sv
module conflict_splitter_test;
  localparam int NB = 4;
  localparam int AW = 8;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [NB*BW-1:0] req_bank = '0;
  logic [NB*AW-1:0] req_addr = '0;
  logic [NB-1:0]    out_valid;
  logic [NB*AW-1:0] out_addr;
  logic [NB*BW-1:0] out_idx;
  logic out_first, out_last, out_conflict_free;

  int total = 0;
  int bad = 0;
  int grp = 0;

  always #2.5 clk = ~clk;

  conflict_splitter #(.NBANK(NB), .ADDR_W(AW)) uut (.*);

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic run_group(input int b0, input int b1, input int b2, input int b3, input bit poke);
    int bk[NB];
    logic [AW-1:0] ad[NB];
    bit pend[NB];
    int cnt[NB];
    int maxc = 0;
    int waves = 0;
    bit left = 1'b1;
    bk[0] = b0; bk[1] = b1; bk[2] = b2; bk[3] = b3;
    grp++;
    for (int i = 0; i < NB; i++) begin
      ad[i] = AW'(8'h40 + 16 * i + grp);
      pend[i] = 1'b1;
      cnt[i] = 0;
    end
    for (int i = 0; i < NB; i++) cnt[bk[i]]++;
    for (int i = 0; i < NB; i++) if (cnt[i] > maxc) maxc = cnt[i];

    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before group", int'(req_ready), 1);
    req_valid = 1'b1;
    for (int i = 0; i < NB; i++) begin
      req_bank[i*BW +: BW] = BW'(bk[i]);
      req_addr[i*AW +: AW] = ad[i];
    end
    @(negedge clk);
    req_valid = poke;
    if (poke) begin
      req_bank = '0;
      req_addr = '1;
    end
    while (left) begin
      bit ev[NB];
      int ei[NB];
      bit any_left = 1'b0;
      for (int b = 0; b < NB; b++) begin
        ev[b] = 1'b0; ei[b] = 0;
        for (int i = NB - 1; i >= 0; i--)
          if (pend[i] && bk[i] == b) begin ev[b] = 1'b1; ei[b] = i; end
      end
      for (int b = 0; b < NB; b++) if (ev[b]) pend[ei[b]] = 1'b0;
      for (int i = 0; i < NB; i++) if (pend[i]) any_left = 1'b1;
      for (int b = 0; b < NB; b++) begin
        chk(out_valid[b] == ev[b], "R4", "slot valid", int'(out_valid[b]), int'(ev[b]));
        if (ev[b] && out_valid[b]) begin
          chk(int'(out_idx[b*BW +: BW]) == ei[b], "R4", "slot winner index",
              int'(out_idx[b*BW +: BW]), ei[b]);
          chk(bk[out_idx[b*BW +: BW]] == b, "R3", "slot bank match",
              bk[out_idx[b*BW +: BW]], b);
          chk(out_addr[b*AW +: AW] == ad[ei[b]], "R6", "slot address",
              int'(out_addr[b*AW +: AW]), int'(ad[ei[b]]));
        end
      end
      chk(out_first == (waves == 0), "R8", "first marker", int'(out_first), int'(waves == 0));
      chk(out_last == !any_left, "R8", "last marker", int'(out_last), int'(!any_left));
      chk(out_conflict_free == (waves == 0 && !any_left), "R7", "conflict free flag",
          int'(out_conflict_free), int'(waves == 0 && !any_left));
      chk(req_ready == 1'b0, poke ? "R9" : "R2", "ready low while issuing", int'(req_ready), 0);
      waves++;
      left = any_left;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(req_ready == 1'b1, "R2", "ready after last wave", int'(req_ready), 1);
    chk(out_valid == '0, "R2", "idle after last wave", int'(out_valid), 0);
    chk(waves == maxc, "R5", "wave count", waves, maxc);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    chk(out_valid == '0, "R1", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    chk(out_first == 1'b0 && out_last == 1'b0, "R8", "markers idle",
        int'({out_first, out_last}), 0);
    chk(out_conflict_free == 1'b0, "R7", "flag idle", int'(out_conflict_free), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog run did not end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    run_group(2, 0, 3, 1, 1'b0);   // R7 permutation, one wave
    run_group(1, 1, 1, 1, 1'b0);   // R5 all on one bank, four waves
    run_group(0, 3, 0, 3, 1'b0);   // R4 two pairs
    run_group(0, 0, 1, 0, 1'b0);   // R5 three deep
    run_group(3, 2, 2, 0, 1'b1);   // R9 input poked while busy
    run_group(0, 1, 2, 3, 1'b0);   // R6 identity
    run_group(3, 3, 3, 2, 1'b0);   // back to back
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule